// File: doc/BRIEF.md
# Programmable Interval Interrupt Timer

This block generates periodic interrupt requests from a programmable interval and keeps a free-running 64-bit real-time clock beside it. Software issues operations through a small command port: each cycle presents an operation code, a 64-bit operand and a flag that forces the operand to zero. An operation takes effect at the next rising clock edge, and only while the privileged-mode input is high. Outside that mode every operation is dropped without any effect.

A countdown counter runs from the programmed interval to zero. When it reaches zero, it raises a sticky request and reloads itself from the interval register, so the request repeats at a fixed rate. The request stays set until a clear operation. The interrupt line is the request gated by an enable bit. Disabling the interrupt masks only the line. The countdown and the request keep running while the line is masked.

Top module: `interval_irq_timer`

## Requirements
- R1: After reset, the request, the interrupt line, the enable bit and the clock value are all 0. The interval register and the countdown are all ones.
- R2: Operation code 1 (load interval) writes the low 32 bits of the operand into the interval register and into the countdown. With a loaded value N, the request first reads 1 after the (N+1)-th rising edge following the load edge.
- R3: While the countdown is non-zero it decrements by one per cycle. At zero it sets the request and reloads from the interval register, so requests recur every N+1 cycles.
- R4: Once set, the request stays at 1 until operation code 2 (clear request) executes. The clear takes effect at the edge on which it is sampled.
- R5: When a clear is sampled on the same edge at which the countdown is at zero, the request stays set.
- R6: Operation code 3 sets the enable bit and operation code 4 clears it. The interrupt line equals the request AND the enable bit. The countdown and the request continue while the enable bit is clear.
- R7: While the privileged-mode input is low, no operation changes any state or output.
- R8: Operation code 5 (load clock) writes the operand into the clock. When the zero-select input is 1, it writes 0 instead of the operand.
- R9: In every cycle without a clock load, the clock increments by one and wraps from all ones to 0.
- R10: An interval of 0 sets the request on every cycle, so no clear can drop it.
- R11: Operation codes 0, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| monitor_mode | input | 1 | Privileged-mode qualifier for all operations |
| cmd_op | input | 3 | Operation code |
| cmd_zero_sel | input | 1 | Replaces the operand with 0 for a clock load |
| cmd_operand | input | 64 | Operation operand |
| irq_request | output | 1 | Sticky interrupt request |
| irq_line | output | 1 | Request gated by the enable bit |
| rtc_value | output | 64 | Real-time clock value |

## Verification
Directed sequences measure the exact first and repeat distances of the request for a small interval, which separates an off-by-one in the reload from a correct period. Other directed sequences place a clear on the zero cycle and on a non-zero cycle, to tell the priority rule apart from plain stickiness. Further sequences issue operations with the privileged input low, issue unused codes, and load the clock with and without zero-select or next to wrap. A seeded random stream then mixes every operation code, small and truncated intervals, and privileged-input toggles. The outputs are compared each cycle against a bench model, which catches ordering errors between a load, a reload and a clear.

// File: rtl/itt_pkg.sv
package itt_pkg;
   typedef enum logic [2:0] {
      OP_IDLE     = 3'd0,
      OP_LD_INTV  = 3'd1,
      OP_CLR_REQ  = 3'd2,
      OP_EN_IRQ   = 3'd3,
      OP_DIS_IRQ  = 3'd4,
      OP_LD_CLOCK = 3'd5
   } itt_op_e;

   typedef struct packed {
      logic ld_intv;
      logic clr_req;
      logic en_irq;
      logic dis_irq;
      logic ld_clock;
   } itt_strobe_t;
endpackage

// File: rtl/itt_cmd_decode.sv
module itt_cmd_decode
   import itt_pkg::*;
(
   input  logic        priv_i,
   input  logic [2:0]  op_i,
   output itt_strobe_t stb_o
);
   always_comb begin
      stb_o = '0;
      if (priv_i) begin
         unique case (op_i)
            OP_LD_INTV:  stb_o.ld_intv  = 1'b1;
            OP_CLR_REQ:  stb_o.clr_req  = 1'b1;
            OP_EN_IRQ:   stb_o.en_irq   = 1'b1;
            OP_DIS_IRQ:  stb_o.dis_irq  = 1'b1;
            OP_LD_CLOCK: stb_o.ld_clock = 1'b1;
            default:     stb_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/itt_countdown.sv
module itt_countdown #(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] operand_i,
   output logic              hit_o
);
   generate
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_width
         $error("itt_countdown: CNT_W must lie in 1..DATA_W");
      end
   endgenerate

   logic [CNT_W-1:0] intv_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   assign load_val = operand_i[CNT_W-1:0];
   assign hit_o    = (cnt_q == '0) && !load_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         intv_q <= '1;
         cnt_q  <= '1;
      end else if (load_i) begin
         intv_q <= load_val;
         cnt_q  <= load_val;
      end else if (cnt_q == '0) begin
         cnt_q  <= intv_q;
      end else begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R2
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(load_val) && intv_q == $past(load_val)));

   // R3
   cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> (cnt_q == $past(intv_q)));
endmodule

// File: rtl/itt_rtc.sv
module itt_rtc #(
   parameter int RTC_W  = 64,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              zero_i,
   input  logic [DATA_W-1:0] operand_i,
   output logic [RTC_W-1:0]  rtc_o
);
   logic [RTC_W-1:0] load_val;

   generate
      if (RTC_W == DATA_W) begin : g_full
         assign load_val = zero_i ? '0 : operand_i;
      end else if (RTC_W < DATA_W) begin : g_trunc
         assign load_val = zero_i ? '0 : operand_i[RTC_W-1:0];
      end else begin : g_wide
         assign load_val = zero_i ? '0 : {{(RTC_W-DATA_W){1'b0}}, operand_i};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rtc_o <= '0;
      else if (load_i) rtc_o <= load_val;
      else             rtc_o <= rtc_o + 1'b1;
   end

   // R9
   rtc_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> (rtc_o == $past(rtc_o) + 1'b1));

   // R8
   rtc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && zero_i) |=> (rtc_o == '0));
endmodule

// File: rtl/itt_irq_ctl.sv
module itt_irq_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_i,
   input  logic clr_i,
   input  logic en_i,
   input  logic dis_i,
   output logic req_o,
   output logic line_o
);
   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     req_o <= 1'b0;
      else if (hit_i) req_o <= 1'b1;
      else if (clr_i) req_o <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= 1'b0;
      else if (en_i)  en_q <= 1'b1;
      else if (dis_i) en_q <= 1'b0;
   end

   assign line_o = req_o & en_q;

   // R4
   req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !clr_i) |=> req_o);

   // R5
   req_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i |=> req_o);

   // R6
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !dis_i) |=> $stable(en_q));
endmodule

// File: rtl/interval_irq_timer.sv
module interval_irq_timer
   import itt_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int RTC_W  = 64,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              monitor_mode,
   input  logic [2:0]        cmd_op,
   input  logic              cmd_zero_sel,
   input  logic [DATA_W-1:0] cmd_operand,
   output logic              irq_request,
   output logic              irq_line,
   output logic [RTC_W-1:0]  rtc_value
);
   itt_strobe_t stb;
   logic        hit;

   itt_cmd_decode u_dec (
      .priv_i (monitor_mode),
      .op_i   (cmd_op),
      .stb_o  (stb)
   );

   itt_countdown #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (stb.ld_intv),
      .operand_i (cmd_operand),
      .hit_o     (hit)
   );

   itt_rtc #(.RTC_W(RTC_W), .DATA_W(DATA_W)) u_rtc (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (stb.ld_clock),
      .zero_i    (cmd_zero_sel),
      .operand_i (cmd_operand),
      .rtc_o     (rtc_value)
   );

   itt_irq_ctl u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_i  (hit),
      .clr_i  (stb.clr_req),
      .en_i   (stb.en_irq),
      .dis_i  (stb.dis_irq),
      .req_o  (irq_request),
      .line_o (irq_line)
   );

   // R7
   priv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!monitor_mode && !hit) |=> ($stable(irq_request) && $stable(irq_line)));

   // R6
   line_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_line |-> irq_request);
endmodule

// File: tb/interval_irq_timer_tb_top.sv
`timescale 1ns/1ps
module interval_irq_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        monitor_mode = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic        cmd_zero_sel = 1'b0;
   logic [63:0] cmd_operand = '0;
   logic        irq_request;
   logic        irq_line;
   logic [63:0] rtc_value;

   int vectors = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;
   string tag = "R1";

   // bench model state
   logic [63:0] m_rtc;
   logic [31:0] m_cnt, m_intv;
   logic        m_req, m_en;

   always #2.5 clk = ~clk;

   interval_irq_timer dut_i (
      .clk(clk), .rst_n(rst_n), .monitor_mode(monitor_mode),
      .cmd_op(cmd_op), .cmd_zero_sel(cmd_zero_sel), .cmd_operand(cmd_operand),
      .irq_request(irq_request), .irq_line(irq_line), .rtc_value(rtc_value)
   );

   function automatic logic accepted(logic mm, logic [2:0] op, logic [2:0] want);
      return mm && (op == want);
   endfunction

   function automatic logic [63:0] f_rtc(logic [63:0] r, logic ld, logic z, logic [63:0] d);
      if (!ld) return r + 64'd1;
      return z ? 64'd0 : d;
   endfunction

   function automatic logic f_hit(logic [31:0] c, logic ld);
      return (c == 32'd0) && !ld;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_rtc = '0; m_cnt = '1; m_intv = '1; m_req = 1'b0; m_en = 1'b0;
      end else begin
         logic ld, hit;
         ld  = accepted(monitor_mode, cmd_op, 3'd1);
         hit = f_hit(m_cnt, ld);
         if (hit) m_req = 1'b1;
         else if (accepted(monitor_mode, cmd_op, 3'd2)) m_req = 1'b0;
         if (accepted(monitor_mode, cmd_op, 3'd3)) m_en = 1'b1;
         else if (accepted(monitor_mode, cmd_op, 3'd4)) m_en = 1'b0;
         if (ld) begin m_intv = cmd_operand[31:0]; m_cnt = cmd_operand[31:0]; end
         else if (m_cnt == 32'd0) m_cnt = m_intv;
         else m_cnt = m_cnt - 32'd1;
         m_rtc = f_rtc(m_rtc, accepted(monitor_mode, cmd_op, 3'd5), cmd_zero_sel, cmd_operand);
      end
   end

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cmp_model();
      chk(tag, {63'd0, irq_request}, {63'd0, m_req});
      chk(tag, {63'd0, irq_line}, {63'd0, m_req & m_en});
      chk(tag, rtc_value, m_rtc);
   endtask

   // drive at negedge, wait one edge, land on next negedge
   task automatic step(logic [2:0] op, logic [63:0] d = '0, logic z = 1'b0, logic mm = 1'b1);
      monitor_mode = mm; cmd_op = op; cmd_operand = d; cmd_zero_sel = z;
      @(negedge clk);
      cmd_op = 3'd0;
      cmd_zero_sel = 1'b0;
      cmp_model();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         finish_run();
      end
   end

   initial begin
      logic [63:0] prev;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state (clock has run one cycle since release)
      chk("R1", {62'd0, irq_request, irq_line}, 64'd0);
      chk("R1", rtc_value, 64'd1);

      tag = "R2";
      step(3'd3);
      step(3'd1, 64'd5);
      for (int i = 0; i < 5; i++) step(3'd0);
      chk("R2", {63'd0, irq_request}, 64'd0);
      step(3'd0);
      chk("R2", {63'd0, irq_request}, 64'd1);
      chk("R6", {63'd0, irq_line}, 64'd1);

      tag = "R4";
      for (int i = 0; i < 3; i++) step(3'd0);
      chk("R4", {63'd0, irq_request}, 64'd1);
      step(3'd4);
      chk("R6", {62'd0, irq_request, irq_line}, 64'd2);
      step(3'd2);
      chk("R4", {63'd0, irq_request}, 64'd0);
      step(3'd0);
      chk("R6", {62'd0, irq_request, irq_line}, 64'd2);

      tag = "R3";
      step(3'd2);
      for (int i = 0; i < 4; i++) step(3'd0);
      chk("R3", {63'd0, irq_request}, 64'd0);
      step(3'd0);
      chk("R3", {63'd0, irq_request}, 64'd1);

      tag = "R5";
      step(3'd2);
      for (int i = 0; i < 4; i++) step(3'd0);
      chk("R5", {63'd0, irq_request}, 64'd0);
      step(3'd2);
      chk("R5", {63'd0, irq_request}, 64'd1);

      tag = "R7";
      step(3'd2, 64'd0, 1'b0, 1'b0);
      chk("R7", {63'd0, irq_request}, 64'd1);
      prev = rtc_value;
      step(3'd5, 64'hDEAD, 1'b0, 1'b0);
      chk("R7", rtc_value, prev + 64'd1);
      step(3'd3, 64'd0, 1'b0, 1'b0);
      chk("R7", {63'd0, irq_line}, 64'd0);

      tag = "R8";
      step(3'd5, 64'h0123_4567_89AB_CDEF);
      chk("R8", rtc_value, 64'h0123_4567_89AB_CDEF);
      step(3'd0);
      chk("R9", rtc_value, 64'h0123_4567_89AB_CDF0);
      step(3'd5, 64'hFFFF_0000_FFFF_0000, 1'b1);
      chk("R8", rtc_value, 64'd0);
      step(3'd5, '1);
      step(3'd0);
      chk("R9", rtc_value, 64'd0);

      tag = "R11";
      step(3'd3);
      prev = rtc_value;
      step(3'd6, 64'd7);
      step(3'd7, 64'd7, 1'b1);
      step(3'd0, 64'd7);
      chk("R11", rtc_value, prev + 64'd3);
      chk("R11", {63'd0, irq_line}, {63'd0, m_req});

      tag = "R10";
      step(3'd1, 64'd0);
      for (int i = 0; i < 4; i++) begin
         step(3'd2);
         chk("R10", {63'd0, irq_request}, 64'd1);
      end

      tag = "R2";
      step(3'd1, 64'hFFFF_FFFF_0000_0003);
      step(3'd2);
      step(3'd2);
      step(3'd0);
      chk("R2", {63'd0, irq_request}, 64'd0);
      step(3'd0);
      chk("R2", {63'd0, irq_request}, 64'd1);

      tag = "R3";
      for (int i = 0; i < 3000; i++) begin
         logic [2:0] op;
         logic [63:0] d;
         op = 3'($urandom_range(0, 7));
         if (op == 3'd1 && ($urandom_range(0, 3) != 0)) op = 3'd0;
         d = {$urandom(), $urandom()};
         if (op == 3'd1) d[31:0] = 32'($urandom_range(0, 20));
         step(op, d, 1'($urandom_range(0, 1)), ($urandom_range(0, 4) != 0));
      end

      finish_run();
   end
endmodule